// File: doc/BRIEF.md
# Raw Float/Integer Register Move Unit

This block transfers bit patterns between the floating-point register path and the integer register path of a core. It does no arithmetic conversion. It offers four operations:

- a 64-bit copy from float to integer;
- a 64-bit copy from integer to float;
- a single-precision narrow from float to integer;
- a single-precision widen from integer to float.

The two single-precision operations behave like a store-single followed by an integer load, or like an integer store followed by a load-single. They never round, never trap and never touch any floating-point exception flag. The register files sit outside the block. The unit only computes the value to write, says which file receives it and, when the record bit is set, produces a 4-bit condition field and names the field it targets.

One operation is accepted in any cycle in which `op_valid` is high. Its result is registered and presented one clock later. A two-state controller tracks whether a result is on the outputs:

- **ST_IDLE** means no result is present.
- **ST_DONE** means a result is present.
- The transition **accept** (ST_IDLE to ST_DONE) fires when an operation arrives.
- The transition **chain** (ST_DONE to ST_DONE) fires when a new operation arrives while a result is showing.
- The transition **drain** (ST_DONE to ST_IDLE) fires when no operation arrives.

Reset forces ST_IDLE.

Top module: `rawmv_unit`

## Requirements
- R1: While reset is asserted and on the first sample after it, `res_valid`, `cr_valid`, `cr_sel` and `dst_fpr` are 0, and `res_data` and `cr_field` are all zeros.
- R2: An operation accepted at a clock edge has its result on the outputs with `res_valid`=1 after that edge. After an edge with no operation, `res_valid` and `cr_valid` are 0, `cr_field` is zero, and `res_data` keeps its last value.
- R3: Operation code 0 (float to integer, 64-bit) and code 1 (integer to float, 64-bit) copy all 64 source bits unchanged.
- R4: Operation code 2 (narrow) handles double biased exponents outside 874..896 by bit selection. Result bit 31 is source bit 63, result bit 30 is source bit 62, and result bits 29..0 are source bits 58..29. Result bits 63..32 are zero and the lower source bits are dropped without rounding.
- R5: Operation code 2 with a double biased exponent e in 874..896 produces a single denormal. The fraction field is {1, source bits 51..0} shifted right by 897-e, bits 51..29 of that shifted value, and the single exponent field is zero.
- R6: Operation code 3 (widen) takes source bits 31..0 as an FP32 pattern. When the single exponent field is 1..254, the result is {w31, w30, three copies of NOT w30, w29..w0, 29 zeros}. When the exponent field is 255, or is 0 with a zero fraction, the three copies are of w30 itself. Source bits 63..32 are ignored.
- R7: Operation code 3 with a zero single exponent field and a nonzero fraction normalises the value. With lz leading zeros in the 23-bit fraction, the double exponent is 896-lz and the double fraction is the single fraction shifted left by lz+1, truncated to 23 bits, followed by 29 zeros.
- R8: With the record bit set, operation codes 0 and 2 set `cr_valid`=1 and `cr_sel`=0. `cr_field` is {LT, GT, EQ, SO}, with bit 3 = LT. LT, GT and EQ come from a signed 64-bit compare of the result against zero, and SO copies `so_in`.
- R9: With the record bit set, operation codes 1 and 3 set `cr_valid`=1 and `cr_sel`=1, and `cr_field` copies the `fp_summary` input.
- R10: With the record bit clear, the result shows `cr_valid`=0, `cr_sel`=0 and `cr_field` zero.
- R11: `dst_fpr` is 1 for operation codes 1 and 3 and 0 for codes 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | Operation code: 0 F2I 64-bit, 1 I2F 64-bit, 2 narrow, 3 widen |
| rec | input | 1 | Record bit: produce a condition field |
| so_in | input | 1 | Summary-overflow bit copied into field 0 |
| fp_summary | input | 4 | Float summary bits copied into field 1 |
| src | input | 64 | Source register value |
| res_valid | output | 1 | A result is present (state ST_DONE) |
| res_data | output | 64 | Value to write to the destination file |
| dst_fpr | output | 1 | 1 = float file, 0 = integer file |
| cr_valid | output | 1 | Condition field is to be written |
| cr_field | output | 4 | Condition field value, bit 3 = LT |
| cr_sel | output | 1 | Target field: 0 = field 0, 1 = field 1 |

## Verification
Every result, whether the moved value, the destination select or the condition field with its target, is due exactly one clock after the edge that accepts its operation. Nothing is produced combinationally. The bench therefore applies each operation on a falling edge and compares all outputs on the next falling edge, midway after the single registering edge. Operations run back to back, so every such compare also checks the chain transition. The drain and reset checks sample one falling edge after the quiet cycle or the reset edge, which is when the cleared values must appear.

// File: rtl/rawmv_pkg.sv
package rawmv_pkg;

    localparam int DBL_W   = 64;
    localparam int SGL_W   = 32;
    localparam int DEXP_W  = 11;
    localparam int SEXP_W  = 8;
    localparam int DFRAC_W = DBL_W - DEXP_W - 1;
    localparam int SFRAC_W = SGL_W - SEXP_W - 1;
    localparam int DBIAS   = (1 << (DEXP_W - 1)) - 1;
    localparam int SBIAS   = (1 << (SEXP_W - 1)) - 1;
    localparam int XTRA_W  = DEXP_W - SEXP_W;
    localparam int PAD_W   = DFRAC_W - SFRAC_W;
    localparam int CR_W    = 4;

    // Double exponent band that maps onto single denormals
    localparam int DEN_HI  = DBIAS - SBIAS;
    localparam int DEN_LO  = DEN_HI - SFRAC_W + 1;

    typedef enum logic [1:0] {
        OP_F2I_D = 2'd0,
        OP_I2F_D = 2'd1,
        OP_F2I_S = 2'd2,
        OP_I2F_S = 2'd3
    } mv_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } mv_state_e;

endpackage

// File: rtl/rawmv_narrow.sv
module rawmv_narrow
    import rawmv_pkg::*;
(
    input  logic [DBL_W-1:0] dval,
    output logic [SGL_W-1:0] sval
);

    localparam int LZ_W   = $clog2(SFRAC_W + 2);
    localparam int LOWTOP = DBL_W - 3 - XTRA_W;

    logic [DEXP_W-1:0]  dexp;
    logic               in_den;
    logic [LZ_W-1:0]    shamt;
    logic [DFRAC_W:0]   mant;
    logic [DFRAC_W:0]   mant_sh;
    logic [SGL_W-1:0]   sel_path;
    logic [SGL_W-1:0]   den_path;

    assign dexp   = dval[DBL_W-2 -: DEXP_W];
    assign in_den = (int'(dexp) >= DEN_LO) && (int'(dexp) <= DEN_HI);

    always_comb begin
        shamt = '0;
        if (in_den) begin
            shamt = LZ_W'(DEN_HI + 1 - int'(dexp));
        end
    end

    assign mant    = {1'b1, dval[DFRAC_W-1:0]};
    assign mant_sh = mant >> shamt;

    // Plain bit selection: sign, top exponent bit, then the next thirty bits
    assign sel_path = {dval[DBL_W-1], dval[DBL_W-2], dval[LOWTOP -: SGL_W-2]};

    // Denormal single: zero exponent field, fraction without rounding
    assign den_path = {dval[DBL_W-1], {SEXP_W{1'b0}}, mant_sh[DFRAC_W-1 -: SFRAC_W]};

    assign sval = in_den ? den_path : sel_path;

endmodule

// File: rtl/rawmv_widen.sv
module rawmv_widen
    import rawmv_pkg::*;
(
    input  logic [SGL_W-1:0] sval,
    output logic [DBL_W-1:0] dval
);

    localparam int LZ_W = $clog2(SFRAC_W + 2);

    logic [SEXP_W-1:0]  sexp;
    logic [SFRAC_W-1:0] sfrac;
    logic               exp_zero;
    logic               exp_ones;
    logic               is_den;
    logic [LZ_W-1:0]    lz;
    logic               hit;
    logic [SFRAC_W-1:0] norm_frac;
    logic [DEXP_W-1:0]  den_exp;
    logic [DBL_W-1:0]   bit_path;
    logic [DBL_W-1:0]   den_path;
    logic               fill;

    assign sexp     = sval[SGL_W-2 -: SEXP_W];
    assign sfrac    = sval[SFRAC_W-1:0];
    assign exp_zero = (sexp == '0);
    assign exp_ones = (sexp == '1);
    assign is_den   = exp_zero && (sfrac != '0);

    // Leading-zero count over the single fraction
    always_comb begin
        lz  = '0;
        hit = 1'b0;
        for (int i = SFRAC_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (sfrac[i]) begin
                    hit = 1'b1;
                end else begin
                    lz = lz + 1'b1;
                end
            end
        end
    end

    assign norm_frac = sfrac << (lz + 1'b1);
    assign den_exp   = DEXP_W'(DEN_HI) - DEXP_W'(lz);

    // Exponent extension: invert the top bit for normal values, copy it otherwise
    assign fill     = (exp_zero || exp_ones) ? sval[SGL_W-2] : ~sval[SGL_W-2];
    assign bit_path = {sval[SGL_W-1], sval[SGL_W-2], {XTRA_W{fill}},
                       sval[SGL_W-3:0], {PAD_W{1'b0}}};
    assign den_path = {sval[SGL_W-1], den_exp, norm_frac, {PAD_W{1'b0}}};

    assign dval = is_den ? den_path : bit_path;

endmodule

// File: rtl/rawmv_cond.sv
module rawmv_cond
    import rawmv_pkg::*;
(
    input  logic [DBL_W-1:0] value,
    input  logic             to_fpr,
    input  logic             so_in,
    input  logic [CR_W-1:0]  fp_summary,
    output logic [CR_W-1:0]  field
);

    logic neg;
    logic zero;

    assign neg  = value[DBL_W-1];
    assign zero = (value == '0);

    always_comb begin
        if (to_fpr) begin
            field = fp_summary;
        end else begin
            field = {neg, ~neg & ~zero, zero, so_in};
        end
    end

endmodule

// File: rtl/rawmv_unit.sv
module rawmv_unit
    import rawmv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic             rec,
    input  logic             so_in,
    input  logic [CR_W-1:0]  fp_summary,
    input  logic [DBL_W-1:0] src,
    output logic             res_valid,
    output logic [DBL_W-1:0] res_data,
    output logic             dst_fpr,
    output logic             cr_valid,
    output logic [CR_W-1:0]  cr_field,
    output logic             cr_sel
);

    mv_state_e        state_q;
    mv_state_e        state_d;
    mv_op_e           op;
    logic [SGL_W-1:0] narrow_val;
    logic [DBL_W-1:0] widen_val;
    logic [DBL_W-1:0] move_val;
    logic             move_fpr;
    logic [CR_W-1:0]  cond_val;

    assign op = mv_op_e'(op_sel);

    rawmv_narrow u_narrow (
        .dval (src),
        .sval (narrow_val)
    );

    rawmv_widen u_widen (
        .sval (src[SGL_W-1:0]),
        .dval (widen_val)
    );

    always_comb begin
        unique case (op)
            OP_F2I_D: move_val = src;
            OP_I2F_D: move_val = src;
            OP_F2I_S: move_val = {{(DBL_W-SGL_W){1'b0}}, narrow_val};
            OP_I2F_S: move_val = widen_val;
            default:  move_val = '0;
        endcase
    end

    assign move_fpr = op_sel[0];

    rawmv_cond u_cond (
        .value      (move_val),
        .to_fpr     (move_fpr),
        .so_in      (so_in),
        .fp_summary (fp_summary),
        .field      (cond_val)
    );

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = op_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = op_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            dst_fpr  <= 1'b0;
            cr_valid <= 1'b0;
            cr_field <= '0;
            cr_sel   <= 1'b0;
        end else if (op_valid) begin
            res_data <= move_val;
            dst_fpr  <= move_fpr;
            cr_valid <= rec;
            cr_field <= rec ? cond_val : '0;
            cr_sel   <= rec & move_fpr;
        end else begin
            cr_valid <= 1'b0;
            cr_field <= '0;
            cr_sel   <= 1'b0;
        end
    end

    assign res_valid = (state_q == ST_DONE);

endmodule

// File: rtl/rawmv_unit_chk.sv
module rawmv_unit_chk
    import rawmv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_sel,
    input logic             rec,
    input logic [CR_W-1:0]  fp_summary,
    input logic [DBL_W-1:0] src,
    input logic             res_valid,
    input logic [DBL_W-1:0] res_data,
    input logic             dst_fpr,
    input logic             cr_valid,
    input logic [CR_W-1:0]  cr_field,
    input logic             cr_sel
);

    a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    a_r2_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !cr_valid && $stable(res_data)));

    a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel[1] == 1'b0) |=> (res_data == $past(src)));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd2) |=> (res_data[DBL_W-1:SGL_W] == '0));

    a_r8_one_relation: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_valid && !cr_sel) |-> ($countones(cr_field[CR_W-1:1]) == 1));

    a_r9_fp_field: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && rec && op_sel[0]) |=> (cr_sel && cr_field == $past(fp_summary)));

    a_r10_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !rec) |=> (!cr_valid && !cr_sel && cr_field == '0));

    a_r11_dst: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (dst_fpr == $past(op_sel[0])));

endmodule

bind rawmv_unit rawmv_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .rec        (rec),
    .fp_summary (fp_summary),
    .src        (src),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .dst_fpr    (dst_fpr),
    .cr_valid   (cr_valid),
    .cr_field   (cr_field),
    .cr_sel     (cr_sel)
);

// File: tb/rawmv_unit_tb.sv
module rawmv_unit_tb;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic        rec;
        logic        so;
        logic [3:0]  fs;
        logic [63:0] src;
        logic [63:0] xd;
        logic [3:0]  xcr;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{4'd8,  2'd0, 1'b1, 1'b0, 4'h0, 64'h3FF0000000000000, 64'h3FF0000000000000, 4'b0100}, // R8 R3
        '{4'd8,  2'd0, 1'b1, 1'b1, 4'h0, 64'hBFF8000000000000, 64'hBFF8000000000000, 4'b1001}, // R8
        '{4'd9,  2'd1, 1'b1, 1'b0, 4'hA, 64'h123456789ABCDEF0, 64'h123456789ABCDEF0, 4'b1010}, // R9 R3
        '{4'd8,  2'd0, 1'b1, 1'b0, 4'h0, 64'h0000000000000000, 64'h0000000000000000, 4'b0010}, // R8
        '{4'd4,  2'd2, 1'b1, 1'b0, 4'h0, 64'h3FF0000000000000, 64'h000000003F800000, 4'b0100}, // R4
        '{4'd4,  2'd2, 1'b0, 1'b0, 4'h0, 64'hFFF0000000000000, 64'h00000000FF800000, 4'b0000}, // R4
        '{4'd5,  2'd2, 1'b1, 1'b0, 4'h0, 64'h3800000000000000, 64'h0000000000400000, 4'b0100}, // R5
        '{4'd5,  2'd2, 1'b0, 1'b0, 4'h0, 64'h36A0000000000000, 64'h0000000000000001, 4'b0000}, // R5
        '{4'd5,  2'd2, 1'b0, 1'b0, 4'h0, 64'h37F8000000000000, 64'h0000000000300000, 4'b0000}, // R5
        '{4'd4,  2'd2, 1'b0, 1'b0, 4'h0, 64'h3FF0000010000000, 64'h000000003F800000, 4'b0000}, // R4
        '{4'd6,  2'd3, 1'b1, 1'b0, 4'h6, 64'hFFFFFFFF3F800000, 64'h3FF0000000000000, 4'b0110}, // R6
        '{4'd6,  2'd3, 1'b0, 1'b0, 4'h0, 64'h00000000C0490FDB, 64'hC00921FB60000000, 4'b0000}, // R6
        '{4'd6,  2'd3, 1'b0, 1'b0, 4'h0, 64'h000000007F800000, 64'h7FF0000000000000, 4'b0000}, // R6
        '{4'd6,  2'd3, 1'b0, 1'b0, 4'h0, 64'h000000007FC00000, 64'h7FF8000000000000, 4'b0000}, // R6
        '{4'd6,  2'd3, 1'b0, 1'b0, 4'h0, 64'h0000000080000000, 64'h8000000000000000, 4'b0000}, // R6
        '{4'd7,  2'd3, 1'b0, 1'b0, 4'h0, 64'h0000000000400000, 64'h3800000000000000, 4'b0000}, // R7
        '{4'd7,  2'd3, 1'b0, 1'b0, 4'h0, 64'h0000000000000001, 64'h36A0000000000000, 4'b0000}, // R7
        '{4'd7,  2'd3, 1'b1, 1'b0, 4'h1, 64'h0000000000300000, 64'h37F8000000000000, 4'b0001}, // R7
        '{4'd10, 2'd1, 1'b0, 1'b1, 4'hF, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 4'b0000}, // R10
        '{4'd8,  2'd0, 1'b1, 1'b1, 4'h0, 64'h0000000000000000, 64'h0000000000000000, 4'b0011}, // R8
        '{4'd8,  2'd2, 1'b1, 1'b1, 4'h0, 64'hBFF0000000000000, 64'h00000000BF800000, 4'b0101}, // R8 R4
        '{4'd8,  2'd0, 1'b1, 1'b0, 4'h0, 64'h8000000000000000, 64'h8000000000000000, 4'b1000}  // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic        rec = 1'b0;
    logic        so_in = 1'b0;
    logic [3:0]  fp_summary = '0;
    logic [63:0] src = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        dst_fpr;
    logic        cr_valid;
    logic [3:0]  cr_field;
    logic        cr_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rawmv_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_sel     (op_sel),
        .rec        (rec),
        .so_in      (so_in),
        .fp_summary (fp_summary),
        .src        (src),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .dst_fpr    (dst_fpr),
        .cr_valid   (cr_valid),
        .cr_field   (cr_field),
        .cr_sel     (cr_sel)
    );

    task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Packs {res_valid, dst_fpr, cr_valid, cr_sel, cr_field, res_data}
    function automatic logic [71:0] outs();
        return {res_valid, dst_fpr, cr_valid, cr_sel, cr_field, res_data};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset held", outs(), 72'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), 72'h0);

        // Table walk, one operation per cycle back to back (R2 chain)
        for (int i = 0; i < NV; i++) begin
            op_valid   = 1'b1;
            op_sel     = VECS[i].op;
            rec        = VECS[i].rec;
            so_in      = VECS[i].so;
            fp_summary = VECS[i].fs;
            src        = VECS[i].src;
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(),
                  {1'b1, VECS[i].op[0], VECS[i].rec, VECS[i].rec & VECS[i].op[0],
                   VECS[i].xcr, VECS[i].xd});
        end

        // R2: drain keeps data, clears valid and condition
        op_valid = 1'b0;
        src      = 64'h5555AAAA5555AAAA;
        @(negedge clk);
        check("R2 drain", outs(), {4'b0000, 4'b0000, 64'h8000000000000000});

        // R11 and R10: widen with record clear lands in float file
        op_valid = 1'b1;
        op_sel   = 2'd3;
        rec      = 1'b0;
        src      = 64'h000000003F800000;
        @(negedge clk);
        check("R11 R10 widen no record", outs(),
              {4'b1100, 4'b0000, 64'h3FF0000000000000});

        // R6: upper source half ignored by widen
        src = 64'hDEADBEEF3F800000;
        @(negedge clk);
        check("R6 upper half ignored", outs(),
              {4'b1100, 4'b0000, 64'h3FF0000000000000});

        // R1: reset mid-stream clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", outs(), 72'h0);
        op_valid = 1'b0;
        rst_n    = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", outs(), 72'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule